// File: doc/BRIEF.md
# Run-Length Compressing Byte Transmitter

This block sits on the transmit path of a parallel port, between a byte source and the transmit FIFO. It watches the outgoing bytes. When it finds three or more equal bytes in a row, it replaces them with a count byte followed by a single copy of the repeated byte. Bytes that do not form such a run go out unchanged. Each output byte carries a tag that marks it as a command (count) byte or as a data byte, so the FIFO can keep the two apart.

Compression runs only when the compression enable is high and the port is in extended-capability mode. If either flag is low, the block forwards bytes straight through in the same cycle. The count field is seven bits wide and holds the run length minus one, so one count byte covers a run of up to 128 bytes. A longer run is split into several pairs. A run ends when a different byte arrives or when a byte marked as the last of a burst is accepted. Either event flushes the pending run.

The controller has four states:
- `ST_IDLE`: no run is pending. In pass-through mode this state also forwards bytes.
- `ST_HOLD`: a run is being counted.
- `ST_CNT`: the count byte is on the output.
- `ST_BYTE`: data copies of the run byte are on the output.

The transitions are:
- IDLE→HOLD: first byte of a run.
- IDLE→BYTE: a lone byte that is the last of its burst.
- HOLD→HOLD: the same byte arrives and the run is not yet full.
- HOLD→CNT: the run is flushed with a length of 3 or more.
- HOLD→BYTE: the run is flushed with a length of 1 or 2, or the mode drops.
- CNT→BYTE: the count byte is taken.
- BYTE→BYTE: more plain copies remain, or the waiting byte is the last of its burst.
- BYTE→HOLD: a waiting byte starts a new run.
- BYTE→IDLE: nothing is waiting.

Top module: `rle_tx_compressor`

## Requirements
- R1: When `rle_en` or `ecp_mode` is low and the block is idle, every input byte is forwarded in the same cycle with `out_is_cmd`=0, and `in_ready` follows `out_ready`.
- R2: With compression active, a run of one or two equal bytes is emitted as that many data bytes (`out_is_cmd`=0).
- R3: With compression active, a run of N equal bytes, 3 ≤ N ≤ 128, is emitted as one command byte with value N-1 (so at least 2), followed by exactly one data byte that carries the run value.
- R4: A different input byte ends the pending run. The run is emitted first, and the new byte then starts a new run.
- R5: An accepted byte with `in_last`=1 is added to its run (or starts a new one), and the pending run is then flushed without waiting for more input.
- R6: A run longer than 128 is emitted as a pair with count 127 for each full 128 bytes. The remainder is then emitted under R2 or R3.
- R7: A command byte has `out_is_cmd`=1 and bit 7 of `out_data` at 0. The count sits in bits 6:0.
- R8: With compression active, `in_ready` is 0 while any output byte is being offered.
- R9: With compression active, an offered output byte keeps its value and its tag until `out_ready` accepts it.
- R10: After reset no output byte is offered, no run is pending, and with compression active `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rle_en | input | 1 | Compression enable |
| ecp_mode | input | 1 | Port is in extended-capability mode |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its burst |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output byte offered |
| out_data | output | 8 | Output byte (count or data) |
| out_is_cmd | output | 1 | 1 = command (count) byte, 0 = data byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
In pass-through mode the output is combinational, so a byte is due at the output in the same cycle it is offered. With compression on, the byte that closes a run is accepted at one clock edge. The count byte appears in the cycle after that edge. The data copy follows one cycle after the count byte is taken. `in_ready` rises again in the cycle after the last copy is taken. The bench does not depend on those exact cycle counts. A scoreboard pops one expected item at every sampled output handshake, which checks order and content under random backpressure. Separate checks run every cycle: one confirms that input is stalled while output is offered, and one confirms that a stalled output byte holds its value and tag.

// File: rtl/rle_tx_pkg.sv
package rle_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_CNT  = 2'd2,
        ST_BYTE = 2'd3
    } rle_state_e;
endpackage

// File: rtl/rle_run_match.sv
module rle_run_match #(
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 8,
    parameter int MAX_RUN = 128
) (
    input  logic [DATA_W-1:0] run_byte,
    input  logic [LEN_W-1:0]  run_len,
    input  logic [DATA_W-1:0] in_data,
    output logic              same_byte,
    output logic              run_full,
    output logic              run_long,
    output logic              run_long_next
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_RUN);
    localparam logic [LEN_W-1:0] LONG_LEN = LEN_W'(3);
    localparam logic [LEN_W-1:0] PRE_LEN  = LEN_W'(2);

    always_comb begin
        same_byte     = (in_data == run_byte);
        run_full      = (run_len == FULL_LEN);
        run_long      = (run_len >= LONG_LEN);
        run_long_next = (run_len >= PRE_LEN);
    end
endmodule

// File: rtl/rle_out_sel.sv
module rle_out_sel
    import rle_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  rle_state_e        state,
    input  logic              pass_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] run_byte,
    input  logic [LEN_W-1:0]  run_len,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_is_cmd
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] count_val;

    always_comb begin
        count_val  = run_len - ONE;
        out_valid  = 1'b0;
        out_data   = in_data;
        out_is_cmd = 1'b0;
        unique case (state)
            ST_IDLE: begin
                out_valid = pass_en & in_valid;
                out_data  = in_data;
            end
            ST_HOLD: begin
                out_valid = 1'b0;
                out_data  = run_byte;
            end
            ST_CNT: begin
                out_valid  = 1'b1;
                out_data   = DATA_W'(count_val);
                out_is_cmd = 1'b1;
            end
            ST_BYTE: begin
                out_valid = 1'b1;
                out_data  = run_byte;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rle_tx_compressor.sv
module rle_tx_compressor
    import rle_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rle_en,
    input  logic              ecp_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_is_cmd,
    input  logic              out_ready
);
    localparam int LEN_W   = CNT_W + 1;
    localparam int MAX_RUN = 2 ** CNT_W;
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    rle_state_e        state_q, state_d;
    logic [DATA_W-1:0] run_byte_q, run_byte_d;
    logic [LEN_W-1:0]  run_len_q, run_len_d;
    logic [DATA_W-1:0] nxt_byte_q, nxt_byte_d;
    logic              nxt_vld_q, nxt_vld_d;
    logic              nxt_last_q, nxt_last_d;

    logic active;
    logic acc;
    logic same_byte, run_full, run_long, run_long_next;

    assign active = rle_en & ecp_mode;

    rle_run_match #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .MAX_RUN(MAX_RUN)
    ) u_match (
        .run_byte     (run_byte_q),
        .run_len      (run_len_q),
        .in_data      (in_data),
        .same_byte    (same_byte),
        .run_full     (run_full),
        .run_long     (run_long),
        .run_long_next(run_long_next)
    );

    rle_out_sel #(
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_out (
        .state     (state_q),
        .pass_en   (~active),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .run_byte  (run_byte_q),
        .run_len   (run_len_q),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_is_cmd(out_is_cmd)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: in_ready = active ? 1'b1 : out_ready;
            ST_HOLD: in_ready = active;
            ST_CNT:  in_ready = 1'b0;
            ST_BYTE: in_ready = 1'b0;
            default: in_ready = 1'b0;
        endcase
    end

    assign acc = active & in_valid & in_ready;

    always_comb begin
        state_d    = state_q;
        run_byte_d = run_byte_q;
        run_len_d  = run_len_q;
        nxt_byte_d = nxt_byte_q;
        nxt_vld_d  = nxt_vld_q;
        nxt_last_d = nxt_last_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc) begin
                    run_byte_d = in_data;
                    run_len_d  = ONE;
                    state_d    = in_last ? ST_BYTE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!active) begin
                    state_d = run_long ? ST_CNT : ST_BYTE;
                end else if (acc) begin
                    if (same_byte && !run_full) begin
                        run_len_d = run_len_q + ONE;
                        if (in_last) begin
                            state_d = run_long_next ? ST_CNT : ST_BYTE;
                        end
                    end else begin
                        nxt_byte_d = in_data;
                        nxt_vld_d  = 1'b1;
                        nxt_last_d = in_last;
                        state_d    = run_long ? ST_CNT : ST_BYTE;
                    end
                end
            end
            ST_CNT: begin
                if (out_ready) begin
                    run_len_d = ONE;
                    state_d   = ST_BYTE;
                end
            end
            ST_BYTE: begin
                if (out_ready) begin
                    if (run_len_q > ONE) begin
                        run_len_d = run_len_q - ONE;
                    end else if (nxt_vld_q) begin
                        run_byte_d = nxt_byte_q;
                        run_len_d  = ONE;
                        nxt_vld_d  = 1'b0;
                        nxt_last_d = 1'b0;
                        state_d    = nxt_last_q ? ST_BYTE : ST_HOLD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            run_byte_q <= '0;
            run_len_q  <= '0;
            nxt_byte_q <= '0;
            nxt_vld_q  <= 1'b0;
            nxt_last_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            run_byte_q <= run_byte_d;
            run_len_q  <= run_len_d;
            nxt_byte_q <= nxt_byte_d;
            nxt_vld_q  <= nxt_vld_d;
            nxt_last_q <= nxt_last_d;
        end
    end

    // Count bytes never set the top bit (R7)
    assert_cmd_msb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_cmd) |-> !out_data[DATA_W-1]);

    // A count byte only stands for a run of three or more (R3)
    assert_cmd_min_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_cmd) |-> (out_data >= DATA_W'(2)));

    // The taken count is followed by a data copy of the run value (R3)
    assert_copy_after_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_is_cmd) |=>
        (out_valid && !out_is_cmd && out_data == $past(run_byte_q)));

    // No input taken while compressed output is offered (R8)
    assert_no_input_while_emitting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && out_valid) |-> !in_ready);

    // Stalled output keeps value and tag (R9)
    assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_is_cmd)));

    // A counting run stays within the seven-bit range (R6)
    assert_run_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (run_len_q >= ONE && run_len_q <= LEN_W'(MAX_RUN)));
endmodule

// File: tb/rle_tx_compressor_tb.sv
module rle_tx_compressor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rle_en = 1'b0;
    logic       ecp_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_is_cmd;
    logic       out_ready = 1'b1;

    int tests = 0;
    int fails = 0;
    string cur_req = "R10";
    bit bp_en = 1'b0;
    logic [8:0] exp_q[$];
    logic [7:0] stim[$];

    always #5 clk = ~clk;

    rle_tx_compressor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rle_en    (rle_en),
        .ecp_mode  (ecp_mode),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_is_cmd(out_is_cmd),
        .out_ready (out_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic add_run(input logic [7:0] b, input int n);
        for (int k = 0; k < n; k++) stim.push_back(b);
    endtask

    // Reference from the requirements: group runs capped at 128
    task automatic model_burst(input bit act);
        int i = 0;
        while (i < stim.size()) begin
            logic [7:0] b;
            int n;
            b = stim[i];
            n = 1;
            if (!act) begin
                exp_q.push_back({1'b0, b});
            end else begin
                while (i + n < stim.size() && stim[i+n] == b && n < 128) n++;
                if (n >= 3) begin
                    exp_q.push_back({1'b1, 8'(n - 1)});
                    exp_q.push_back({1'b0, b});
                end else begin
                    for (int k = 0; k < n; k++) exp_q.push_back({1'b0, b});
                end
            end
            i += n;
        end
    endtask

    task automatic send_burst();
        for (int i = 0; i < stim.size(); i++) begin
            @(posedge clk); #2;
            in_valid = 1'b1;
            in_data  = stim[i];
            in_last  = (i == stim.size() - 1);
            do @(negedge clk); while (!in_ready);
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_burst(input string req);
        int waitc = 0;
        cur_req = req;
        model_burst(rle_en && ecp_mode);
        send_burst();
        while (exp_q.size() != 0 && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(out_valid == 1'b0, req, out_valid, 0);
        exp_q.delete();
        stim.delete();
    endtask

    // Backpressure source
    always @(posedge clk) begin
        #1;
        out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
    end

    // Monitor / scoreboard
    bit         stall_prev = 1'b0;
    logic [8:0] stall_val;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev)
                check(out_valid && {out_is_cmd, out_data} == stall_val, "R9",
                      {out_valid, out_is_cmd, out_data}, {1'b1, stall_val});
            stall_prev = rle_en && ecp_mode && out_valid && !out_ready;
            stall_val  = {out_is_cmd, out_data};
            if (rle_en && ecp_mode && out_valid)
                check(!in_ready, "R8", in_ready, 0);
            if (out_valid && out_ready) begin
                if (out_is_cmd) check(!out_data[7], "R7", out_data, out_data & 8'h7f);
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, {out_is_cmd, out_data}, 9'h1ff);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check({out_is_cmd, out_data} == e, cur_req, {out_is_cmd, out_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rle_en = 1'b1;
        ecp_mode = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", out_valid, 0);
        check(in_ready == 1'b1, "R10", in_ready, 1);

        // R1: pass-through with enable low, then with mode low
        rle_en = 1'b0;
        add_run(8'hA5, 4); add_run(8'h12, 1); add_run(8'h34, 1);
        run_burst("R1");
        rle_en = 1'b1; ecp_mode = 1'b0;
        add_run(8'h77, 5); add_run(8'h01, 2);
        run_burst("R1");
        ecp_mode = 1'b1;

        // R2: short runs stay plain
        add_run(8'h55, 2); add_run(8'h66, 1); add_run(8'h77, 2);
        run_burst("R2");

        // R3 and R4: long runs broken by different bytes
        add_run(8'h41, 9); add_run(8'h42, 3); add_run(8'h43, 1);
        run_burst("R4");

        // R5: burst end flushes a run
        add_run(8'h10, 3);
        run_burst("R5");
        add_run(8'h20, 1);
        run_burst("R5");

        // R6: splitting past 128
        add_run(8'hAA, 128);
        run_burst("R6");
        add_run(8'hAA, 130); add_run(8'hBB, 131); add_run(8'hCC, 1);
        run_burst("R6");

        // R7: top-bit data values in runs
        add_run(8'h80, 5); add_run(8'hFF, 3);
        run_burst("R7");

        // R9 and R8 under backpressure
        bp_en = 1'b1;
        add_run(8'h3C, 4); add_run(8'h3D, 1); add_run(8'h3C, 2); add_run(8'h00, 7);
        add_run(8'h99, 140);
        run_burst("R9");
        rle_en = 1'b0;
        add_run(8'h5A, 3); add_run(8'h5B, 2);
        run_burst("R1");
        rle_en = 1'b1;
        bp_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule